// File: doc/BRIEF.md
# Level-Programmable GPI Interrupt Controller

This block watches a bank of general-purpose input lines and turns level conditions on them into a single active-low interrupt. Each line has a programmable polarity bit and an enable bit. A line is active when its level bit is 1 and the input is high, or when its level bit is 0 and the input is low. While an enabled line is active, the block latches a sticky status bit for that line. Any latched status bit sets a summary flag, and the flag drives the interrupt pin low.

Software reaches the block through a byte-wide strobe bus. Every per-line quantity (synchronized input level, latched status, polarity, enable) is packed into byte registers, line 8·b+j in bit j of byte b. A status byte clears only on the second of two reads, and only for lines whose condition has gone away by that read. The summary flag is cleared by writing a 1 to it.

Register addresses, for the default of 18 lines (three bytes per kind): 0–2 input level (read-only), 3–5 latched status (read-only), 6–8 polarity, 9–11 enable, 12 summary flag in bit 0.

Top module: `gpi_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1 and the status, polarity, enable and flag registers all read 0.
- R2: Polarity (addresses 6–8) and enable (9–11) registers read back what was written, line 8·b+j in bit j of byte b. Bits above the last line read 0. rdata changes only in the cycle after an rd_en strobe.
- R3: An enabled line latches its status bit when it is at its active level: high when its polarity bit is 1, low when it is 0. A line whose enable bit is 0 never sets its status bit.
- R4: Reads of a status byte alternate between arming and clearing. The first read only arms the byte and clears nothing. The next read of that byte clears every bit of the byte whose line is inactive at that read. A read returns the value held before any clear.
- R5: If a line is still active, or becomes active, in the cycle of the clearing read, its status bit stays set.
- R6: The summary flag (bit 0 of address 12) is set in the cycle after any status bit is set, and irq_n is low exactly while the flag is set.
- R7: A write with wdata bit 0 = 1 to address 12 clears the flag, unless a status bit is still set. A write with bit 0 = 0 has no effect.
- R8: The input-level registers (addresses 0–2) show the synchronized input of every line, whatever its enable bit.
- R9: The inputs pass through two synchronizer flops. A status bit is set on the third rising edge after its input changes, and irq_n falls on the fourth.
- R10: Writes to the input-level and status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi_in | input | NUM_LINES | Asynchronous input lines |
| rd_en | input | 1 | Read strobe for addr |
| wr_en | input | 1 | Write strobe for addr/wdata |
| addr | input | ADDR_W | Byte register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| irq_n | output | 1 | Active-low interrupt, low while the summary flag is set |

## Verification
A read's data appears one edge after its strobe, so the scoreboard pops the expected byte at the falling edge that follows the strobe's capturing edge. An input change reaches a status bit on the third rising edge and irq_n on the fourth. The latency test therefore samples irq_n at the falling edges after edges one to four, and requires it high on the first three and low on the fourth. All other input changes are followed by a six-cycle wait before any read, so every comparison sees settled state. Flag writes are followed by a read or a pin check at least one edge later.

// File: rtl/gpi_irq_pkg.sv
package gpi_irq_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        KIND_LEVEL,
        KIND_STATUS,
        KIND_POL,
        KIND_ENABLE,
        KIND_FLAG,
        KIND_NONE
    } reg_kind_e;

    function automatic int unsigned bytes_for(int unsigned lines);
        return (lines + BYTE_W - 1) / BYTE_W;
    endfunction

    // Four banks of nb byte registers each, then one flag register.
    function automatic reg_kind_e decode_kind(int unsigned a, int unsigned nb);
        if (a < nb)          return KIND_LEVEL;
        else if (a < 2 * nb) return KIND_STATUS;
        else if (a < 3 * nb) return KIND_POL;
        else if (a < 4 * nb) return KIND_ENABLE;
        else if (a == 4 * nb) return KIND_FLAG;
        return KIND_NONE;
    endfunction

    function automatic int unsigned decode_byte(int unsigned a, int unsigned nb);
        return a % nb;
    endfunction

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int unsigned WIDTH  = 18,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpi_status_bank.sv
module gpi_status_bank #(
    parameter int unsigned NUM_LINES = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_lvl,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] status
);

    logic [NUM_LINES-1:0] cond;
    logic [NUM_LINES-1:0] status_d, status_q;

    // A line is active when its level matches its polarity bit.
    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            assign cond[g] = en[g] & ~(line_lvl[g] ^ pol[g]);
        end
    endgenerate

    // Setting has priority over a clear in the same cycle.
    always_comb begin
        status_d = cond | (status_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;

endmodule

// File: rtl/gpi_irq_ctrl.sv
module gpi_irq_ctrl #(
    parameter int unsigned NUM_LINES   = 18,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] gpi_in,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 irq_n
);
    import gpi_irq_pkg::*;

    localparam int unsigned NUM_BYTES = bytes_for(NUM_LINES);
    localparam int unsigned PAD_W     = NUM_BYTES * BYTE_W;
    localparam logic [PAD_W-1:0] LINE_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_LINES);

    typedef struct packed {
        logic [PAD_W-1:0]     pol;
        logic [PAD_W-1:0]     en;
        logic [NUM_BYTES-1:0] arm;
        logic                 flag;
        logic [7:0]           rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] line_status;
    logic [NUM_LINES-1:0] clr_lines;
    logic [NUM_BYTES-1:0] clr_bytes;
    logic [PAD_W-1:0]     lvl_pad, stat_pad;
    reg_kind_e            kind;
    int unsigned          bidx;
    logic                 flag_q;

    gpi_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gpi_in),
        .dout  (sync_lvl)
    );

    gpi_status_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_lvl (sync_lvl),
        .pol      (r_q.pol[NUM_LINES-1:0]),
        .en       (r_q.en[NUM_LINES-1:0]),
        .clr      (clr_lines),
        .status   (line_status)
    );

    assign lvl_pad  = PAD_W'(sync_lvl);
    assign stat_pad = PAD_W'(line_status);

    always_comb begin
        r_d       = r_q;
        clr_bytes = '0;
        kind      = decode_kind(int'(addr), NUM_BYTES);
        bidx      = decode_byte(int'(addr), NUM_BYTES);

        if (rd_en) begin
            case (kind)
                KIND_LEVEL:  r_d.rdata = lvl_pad[bidx*BYTE_W +: BYTE_W];
                KIND_STATUS: begin
                    r_d.rdata = stat_pad[bidx*BYTE_W +: BYTE_W];
                    // Reads of a status byte alternate: arm, then clear.
                    if (r_q.arm[bidx]) begin
                        clr_bytes[bidx] = 1'b1;
                        r_d.arm[bidx]   = 1'b0;
                    end else begin
                        r_d.arm[bidx]   = 1'b1;
                    end
                end
                KIND_POL:    r_d.rdata = r_q.pol[bidx*BYTE_W +: BYTE_W];
                KIND_ENABLE: r_d.rdata = r_q.en[bidx*BYTE_W +: BYTE_W];
                KIND_FLAG:   r_d.rdata = {7'd0, r_q.flag};
                default:     r_d.rdata = 8'd0;
            endcase
        end

        if (wr_en) begin
            case (kind)
                KIND_POL:    r_d.pol[bidx*BYTE_W +: BYTE_W] = wdata;
                KIND_ENABLE: r_d.en[bidx*BYTE_W +: BYTE_W]  = wdata;
                default:     ;
            endcase
        end
        r_d.pol = r_d.pol & LINE_MASK;
        r_d.en  = r_d.en  & LINE_MASK;

        // Any latched line holds the flag; a one written to bit 0 drops it.
        r_d.flag = (|line_status) |
                   (r_q.flag & ~(wr_en && (kind == KIND_FLAG) && wdata[0]));

        for (int i = 0; i < NUM_LINES; i++) begin
            clr_lines[i] = clr_bytes[i / BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_q = r_q.flag;
    assign rdata  = r_q.rdata;
    assign irq_n  = ~flag_q;

endmodule

// File: rtl/gpi_irq_ctrl_chk.sv
module gpi_irq_ctrl_chk #(
    parameter int unsigned NUM_LINES = 18,
    parameter int unsigned ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [7:0]           wdata,
    input logic [7:0]           rdata,
    input logic [NUM_LINES-1:0] en,
    input logic [NUM_LINES-1:0] status,
    input logic                 flag
);
    localparam int unsigned NB        = (NUM_LINES + 7) / 8;
    localparam int unsigned STAT_LO   = NB;
    localparam int unsigned STAT_HI   = 2 * NB;
    localparam int unsigned FLAG_ADDR = 4 * NB;

    // R3: a status bit can only rise for a line that was enabled.
    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(en)) == '0));

    // R4: a status bit can only fall right after a status-byte read.
    assert_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status) != '0) |->
        $past(rd_en && (int'(addr) >= STAT_LO) && (int'(addr) < STAT_HI)));

    // R6: a latched line forces the flag on the next edge.
    assert_flag_follows_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |=> flag);

    // R7: the flag only drops after a one is written to it.
    assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_en && (int'(addr) == FLAG_ADDR) && wdata[0]));

    // R2: read data holds when there was no read strobe.
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

endmodule

bind gpi_irq_ctrl gpi_irq_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .en     (r_q.en[NUM_LINES-1:0]),
    .status (line_status),
    .flag   (flag_q)
);

// File: tb/gpi_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpi_irq_ctrl_tb;

    localparam int NL = 18;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] gpi_in = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq_n;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #2 clk = ~clk;

    gpi_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .gpi_in(gpi_in), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    // Monitor: one expected byte is due per read strobe, one edge later.
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read data actual=%02h expected=none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%02h expected=%02h", t, rdata, e);
                end
            end
        end
    end

    task automatic rd(input int a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        addr  = AW'(a);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr  = AW'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s: irq_n actual=%0b expected=%0b", t, irq_n, e);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state (status reads also arm bytes 0..2)
        chk_irq(1'b1, "R1 reset irq_n");
        rd(3, 8'h00, "R1 status0");
        rd(4, 8'h00, "R1 status1");
        rd(5, 8'h00, "R1 status2");
        rd(6, 8'h00, "R1 polarity0");
        rd(9, 8'h00, "R1 enable0");
        rd(12, 8'h00, "R1 flag");

        // R2 polarity readback, unused bits dropped
        wr(6, 8'hFF);
        wr(7, 8'h00);
        wr(8, 8'hFF);
        rd(8, 8'h03, "R2 polarity2 upper bits");
        rd(6, 8'hFF, "R2 polarity0");

        // R8 raw levels; R3 disabled lines stay clear
        gpi_in = 18'h20081;
        settle();
        rd(0, 8'h81, "R8 level0");
        rd(1, 8'h00, "R8 level1");
        rd(2, 8'h02, "R8 level2");
        chk_irq(1'b1, "R3 disabled lines no irq");

        // R3 high- and low-active lines; R6 flag and pin
        wr(9, 8'hFF);
        wr(10, 8'hFF);
        wr(11, 8'h03);
        rd(11, 8'h03, "R2 enable2");
        settle();
        chk_irq(1'b0, "R6 irq asserted");
        rd(12, 8'h01, "R6 flag set");
        rd(3, 8'h81, "R3 high-active status0"); // clearing read, lines still active

        // R4 arm then clear
        gpi_in = 18'h0FF00;
        settle();
        rd(3, 8'h81, "R4 first read arms");
        rd(3, 8'h81, "R4 second read returns old");
        rd(3, 8'h00, "R4 cleared after second read");
        rd(4, 8'hFF, "R3 low-active status1");
        rd(4, 8'h00, "R4 status1 cleared");
        rd(5, 8'h02, "R3 status2");
        rd(5, 8'h00, "R4 status2 cleared");
        rd(12, 8'h01, "R6 flag sticky");
        chk_irq(1'b0, "R6 irq sticky");

        // R7 write-one-to-clear
        wr(12, 8'h00);
        rd(12, 8'h01, "R7 zero write ignored");
        wr(12, 8'h01);
        rd(12, 8'h00, "R7 flag cleared");
        chk_irq(1'b1, "R7 irq released");

        // R5 clearing read while still active
        gpi_in = 18'h0FF01;
        settle();
        rd(3, 8'h01, "R5 clearing read active");
        rd(3, 8'h01, "R5 arm read");
        rd(3, 8'h01, "R5 clearing read again");
        rd(3, 8'h01, "R5 still set");
        gpi_in = 18'h0FF00;
        settle();
        rd(3, 8'h01, "R4 clear after release");
        rd(3, 8'h00, "R4 cleared");
        wr(12, 8'h01);
        rd(12, 8'h00, "R7 flag cleared 2");

        // R7 flag cannot be cleared while a line is latched
        gpi_in = 18'h0FD00;
        settle();
        chk_irq(1'b0, "R6 line9 irq");
        wr(12, 8'h01);
        repeat (2) @(negedge clk);
        chk_irq(1'b0, "R7 flag held by status");
        rd(12, 8'h01, "R7 flag still set");

        gpi_in = 18'h0FF00;
        settle();
        rd(4, 8'h02, "R4 status1 line9 clear");
        rd(4, 8'h00, "R4 status1 line9 gone");
        wr(12, 8'h01);
        chk_irq(1'b1, "R7 irq released 2");

        // R10 writes to read-only registers
        wr(4, 8'hFF);
        wr(0, 8'hFF);
        rd(4, 8'h00, "R10 status write ignored");
        rd(0, 8'h00, "R10 level write ignored");
        rd(12, 8'h00, "R10 flag untouched");

        // R9 latency: irq_n falls on the fourth edge after the change
        @(negedge clk);
        gpi_in = 18'h0FF02;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk_irq(1'b1, $sformatf("R9 edge %0d", k));
        end
        @(negedge clk);
        chk_irq(1'b0, "R9 edge 4");
        rd(3, 8'h02, "R9 status line1");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule